// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple request port and the command pins of a single-data-rate SDRAM with four banks. A client presents a read or write with its bank, row and column. The sequencer opens the row with an activate command. It then issues the column command with auto-precharge, so every access closes its own row (closed-page policy). All spacing between commands is counted in clocks from parameters. The bursts are one beat long. Write data leaves on the data bus in the cycle of the write command. Read data is captured from the bus a programmed CAS latency after the read command.

After reset the sequencer first waits a configurable settling time. It then brings the memory up with a precharge of all banks, two auto-refreshes and a mode-register load. From then on an interval timer requests an auto-refresh. That refresh is issued at the next idle point, ahead of any waiting access. Requests use a valid/ready handshake, so a client is held off during initialisation, during refresh and while an access is in flight.

The controller states are:
- POWERUP, INIT_PRE, INIT_REF1, INIT_REF2 and INIT_MRS.
- IDLE, which goes to REF when a refresh is pending, otherwise to ACT when a request is valid.
- ACT, which goes to WAIT and then RW.
- RW, which goes to WAIT and then IDLE.
- REF, which goes to WAIT and then IDLE.
- WAIT, a shared countdown that hands over to a stored return state.

Every command state lasts one clock. All timing parameters must be at least 2.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset release the sequencer issues NOPs for exactly INIT_WAIT clocks. It then issues, in this order: a precharge with A10=1, an auto-refresh, a second auto-refresh and a mode-register set. req_ready stays low until the mode-register set has been issued.
- R2: The mode-register set drives BA=0 and all address bits zero, except A6..A4. A6..A4 is 010 for CAS latency 2 and 011 for CAS latency 3. The value is 0x030 at CL=3, which gives burst length 1, sequential order and burst write. No command follows within T_MRD clocks.
- R3: Commands on {cs_n,ras_n,cas_n,we_n} use these codes: 0000 mode set, 0001 auto-refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0111 NOP. No other code is ever driven.
- R4: Each accepted request produces an activate carrying its bank on BA and its row on A12..A0. Exactly T_RCD clocks later a read or write follows with the same bank, the column on A9..A0, A10=1 and A12..A11=0.
- R5: An activate comes no sooner than the largest of these, counted from the earlier commands:
  - T_RC and T_RAS+T_RP after the previous activate;
  - T_RP+1 after a read;
  - T_WR+T_RP after a write;
  - T_RP after a precharge.
- R6: An auto-refresh or mode set is issued only with all banks idle, under the same bounds as R5. Any command after an auto-refresh waits at least T_RC clocks.
- R7: Once initialisation is done, auto-refreshes are issued at most REF_INTERVAL+16 clocks apart, even under a continuous request stream. A pending refresh is served before a waiting request.
- R8: sd_dq_oe is high only in the write-command cycle. In that cycle sd_dq_out holds the request's write data.
- R9: rd_valid pulses for one clock after the rising edge that is CL edges after the edge sampling a read. rd_data then holds what sd_dq_in carried at that edge.
- R10: req_ready is high only in IDLE with no refresh pending, and only while the pins show NOP. Requests are executed in acceptance order, one access per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | DATA_W | Captured read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed address |
| sd_dq_out | output | DATA_W | Data toward memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | DATA_W | Data from memory |

## Verification
Results fall due at fixed offsets from their causes:
- The precharge-all is due exactly INIT_WAIT clocks after reset release.
- A read or write is due exactly T_RCD clocks after its activate.
- Write data is due in the same clock as the write command.
- The memory side must present read data CL clocks after the read.
- rd_valid is due one clock after that.

The bench samples every output at the falling edge and numbers the cycles. A behavioural model keeps queues of pending requests, read returns and strobe times. In every cycle the model compares the pins against these precise cycle numbers, and against lower bounds for spacing that has only a minimum.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111,
        CMD_DES = 4'b1111
    } sd_cmd_t;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_INIT_PRE,
        ST_INIT_REF1,
        ST_INIT_REF2,
        ST_INIT_MRS,
        ST_IDLE,
        ST_REF,
        ST_ACT,
        ST_RW,
        ST_WAIT
    } seq_state_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Mode word: burst length 1, sequential, burst write, CAS latency code.
    function automatic logic [12:0] mode_word(input int cl);
        logic [12:0] w;
        w = '0;
        w[6:4] = (cl == 2) ? 3'b010 : 3'b011;
        return w;
    endfunction

endpackage

// File: rtl/sdram_pin_drv.sv
module sdram_pin_drv
    import sdram_seq_pkg::*;
(
    input  sd_cmd_t cmd,
    output logic    cs_n,
    output logic    ras_n,
    output logic    cas_n,
    output logic    we_n
);
    assign {cs_n, ras_n, cas_n, we_n} = cmd;
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
    parameter int REF_INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ack,
    output logic pend
);
    localparam int RW = $clog2(REF_INTERVAL);

    logic [RW-1:0] cnt;
    logic          wrap;

    assign wrap = run && (cnt == RW'(REF_INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (!run || wrap) cnt <= '0;
            else              cnt <= cnt + 1'b1;
            if (wrap)         pend <= 1'b1;
            else if (ack)     pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
    parameter int CL     = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [CL-1:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            pipe     <= {pipe[CL-2:0], issue};
            rd_valid <= pipe[CL-1];
            if (pipe[CL-1]) rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 10,
    parameter int ADDR_W       = 13,
    parameter int DATA_W       = 8,
    parameter int CL           = 3,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 6,
    parameter int T_RC         = 9,
    parameter int T_WR         = 2,
    parameter int T_MRD        = 2,
    parameter int INIT_WAIT    = 20000,
    parameter int REF_INTERVAL = 1040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);
    // Gap from column command (with auto-precharge) to next activate or refresh.
    localparam int G_RD    = max2(max2(T_RC - T_RCD, T_RAS + T_RP - T_RCD),
                                  max2(T_RP + 1, CL + 1));
    localparam int G_WR    = max2(max2(T_RC - T_RCD, T_RAS + T_RP - T_RCD),
                                  T_WR + T_RP);
    localparam int CNT_MAX = max2(INIT_WAIT, max2(T_RC, max2(G_RD, G_WR)));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    seq_state_t        state, state_nx, ret_state, ret_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              take;
    logic              init_done;
    logic              ref_pend;
    sd_cmd_t           cmd;

    logic              q_wr;
    logic [BANK_W-1:0] q_bank;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic [DATA_W-1:0] q_wdata;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        ret_nx   = ret_state;
        cnt_nx   = cnt;
        take     = 1'b0;
        unique case (state)
            ST_POWERUP: begin
                if (cnt == '0) state_nx = ST_INIT_PRE;
                else           cnt_nx   = cnt - 1'b1;
            end
            ST_INIT_PRE: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_INIT_REF1;
                cnt_nx   = CNT_W'(T_RP - 2);
            end
            ST_INIT_REF1: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_INIT_REF2;
                cnt_nx   = CNT_W'(T_RC - 2);
            end
            ST_INIT_REF2: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_INIT_MRS;
                cnt_nx   = CNT_W'(T_RC - 2);
            end
            ST_INIT_MRS: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_IDLE;
                cnt_nx   = CNT_W'(T_MRD - 2);
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    state_nx = ST_REF;
                end else if (req_valid) begin
                    take     = 1'b1;
                    state_nx = ST_ACT;
                end
            end
            ST_REF: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_IDLE;
                cnt_nx   = CNT_W'(T_RC - 2);
            end
            ST_ACT: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_RW;
                cnt_nx   = CNT_W'(T_RCD - 2);
            end
            ST_RW: begin
                state_nx = ST_WAIT;
                ret_nx   = ST_IDLE;
                cnt_nx   = q_wr ? CNT_W'(G_WR - 2) : CNT_W'(G_RD - 2);
            end
            ST_WAIT: begin
                if (cnt == '0) state_nx = ret_state;
                else           cnt_nx   = cnt - 1'b1;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            ret_state <= ST_IDLE;
            cnt       <= CNT_W'(INIT_WAIT - 1);
            init_done <= 1'b0;
        end else begin
            state     <= state_nx;
            ret_state <= ret_nx;
            cnt       <= cnt_nx;
            if (state == ST_INIT_MRS) init_done <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            q_wr    <= req_write;
            q_bank  <= req_bank;
            q_row   <= req_row;
            q_col   <= req_col;
            q_wdata <= req_wdata;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        cmd      = CMD_NOP;
        sd_ba    = '0;
        sd_addr  = '0;
        sd_dq_oe = 1'b0;
        unique case (state)
            ST_INIT_PRE: begin
                cmd         = CMD_PRE;
                sd_addr[10] = 1'b1;
            end
            ST_INIT_REF1, ST_INIT_REF2, ST_REF: cmd = CMD_REF;
            ST_INIT_MRS: begin
                cmd     = CMD_MRS;
                sd_addr = ADDR_W'(mode_word(CL));
            end
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_ba   = q_bank;
                sd_addr = ADDR_W'(q_row);
            end
            ST_RW: begin
                cmd         = q_wr ? CMD_WR : CMD_RD;
                sd_ba       = q_bank;
                sd_addr     = ADDR_W'(q_col);
                sd_addr[10] = 1'b1;
                sd_dq_oe    = q_wr;
            end
            ST_POWERUP, ST_IDLE, ST_WAIT: cmd = CMD_NOP;
        endcase
    end

    assign sd_dq_out = q_wdata;
    assign req_ready = (state == ST_IDLE) && !ref_pend;

    sdram_pin_drv u_pins (
        .cmd   (cmd),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n)
    );

    sdram_ref_timer #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_done),
        .ack   (state == ST_REF),
        .pend  (ref_pend)
    );

    sdram_rd_capture #(.CL(CL), .DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    ((state == ST_RW) && !q_wr),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int CL     = 3,
    parameter int T_RCD  = 2,
    parameter int T_RC   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              sd_dq_oe,
    input logic              req_ready,
    input logic              rd_valid
);
    localparam int SA_W = $clog2(T_RC + 1) + 1;

    logic [3:0]      pins;
    logic            is_act, is_rd, is_wr, is_ref, is_mrs, is_nop;
    logic [SA_W-1:0] since_act;

    assign pins   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_act = (pins == 4'b0011);
    assign is_rd  = (pins == 4'b0101);
    assign is_wr  = (pins == 4'b0100);
    assign is_ref = (pins == 4'b0001);
    assign is_mrs = (pins == 4'b0000);
    assign is_nop = (pins == 4'b0111);

    always_ff @(posedge clk) begin
        if (!rst_n)                      since_act <= SA_W'(T_RC);
        else if (is_act)                 since_act <= SA_W'(1);
        else if (since_act < SA_W'(T_RC)) since_act <= since_act + 1'b1;
    end

    // R4
    rw_after_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> (since_act == SA_W'(T_RCD)));

    // R4
    auto_pre_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd || is_wr) |-> sd_addr[10]);

    // R8
    dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> is_wr);

    // R10
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> is_nop);

    // R6
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (since_act >= SA_W'(T_RC)));

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R2
    mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sd_addr == ADDR_W'(mode_word(CL))));
endmodule

bind sdram_cmd_seq sdram_seq_chk #(
    .ADDR_W (ADDR_W),
    .CL     (CL),
    .T_RCD  (T_RCD),
    .T_RC   (T_RC)
) u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_dq_oe  (sd_dq_oe),
    .req_ready (req_ready),
    .rd_valid  (rd_valid)
);

// File: tb/test_sdram_cmd_seq.sv
`timescale 1ns/1ps
module test_sdram_cmd_seq;
    localparam int CL = 3, T_RCD = 2, T_RP = 2, T_RAS = 6, T_RC = 9;
    localparam int T_WR = 2, T_MRD = 2, INIT_WAIT = 40, REF_INTERVAL = 200;
    localparam int SLACK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0] req_col = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, rd_valid;
    logic [7:0] rd_data;
    logic       sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [1:0] sd_ba;
    logic [12:0] sd_addr;
    logic [7:0] sd_dq_out;
    logic [7:0] sd_dq_in = '0;

    sdram_cmd_seq #(
        .CL(CL), .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
        .T_WR(T_WR), .T_MRD(T_MRD), .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INTERVAL)
    ) i_sdram_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #4 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int patt(input int key);
        return (key ^ (key >> 8) ^ 8'h5A) & 255;
    endfunction

    // ---------------- reference model ----------------
    int  mem [int];
    bit  qw[$]; int qb[$]; int qr[$]; int qc[$]; int qd[$];
    int  drv_t[$]; int drv_d[$]; int rv_t[$]; int rv_d[$];
    int  ncyc = 0, rel = -1, step = 0, mrs_cyc = 0, prev_ref = 0, ref_cnt = 0;
    int  l_act = -1000, l_pre = -1000, l_ref = -1000, l_mrs = -1000;
    int  l_rd = -1000, l_wr = -1000;

    task automatic idle_checks(input int n, input string req);
        chk(n - l_act >= T_RC, req, n - l_act, T_RC);
        chk(n - l_act >= T_RAS + T_RP, req, n - l_act, T_RAS + T_RP);
        chk(n - l_rd >= T_RP + 1, req, n - l_rd, T_RP + 1);
        chk(n - l_wr >= T_WR + T_RP, req, n - l_wr, T_WR + T_RP);
        chk(n - l_pre >= T_RP, req, n - l_pre, T_RP);
        chk(n - l_ref >= T_RC, "R6", n - l_ref, T_RC);
        chk(n - l_mrs >= T_MRD, "R2", n - l_mrs, T_MRD);
    endtask

    always @(negedge clk) begin
        int n;
        logic [3:0] c;
        ncyc++;
        n = ncyc;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        if (n == 2) begin
            chk(c == 4'b0111, "R1 reset cmd", c, 4'b0111);
            chk(!req_ready && !rd_valid && !sd_dq_oe, "R1 reset outputs",
                {req_ready, rd_valid, sd_dq_oe}, 0);
        end
        if (rst_n && rel < 0) rel = n;
        if (rst_n) begin
            // rd_valid timing (R9)
            if (rv_t.size() > 0 && rv_t[0] == n) begin
                chk(rd_valid, "R9 strobe", rd_valid, 1);
                chk(rd_data == rv_d[0], "R9 data", rd_data, rv_d[0]);
                void'(rv_t.pop_front()); void'(rv_d.pop_front());
            end else chk(!rd_valid, "R9 idle", rd_valid, 0);
            if (c != 4'b0100) chk(!sd_dq_oe, "R8 oe", sd_dq_oe, 0);
            if (req_ready) chk(c == 4'b0111, "R10 ready nop", c, 4'b0111);
            if (step < 4) chk(!req_ready, "R1 ready in init", req_ready, 0);
            if (req_valid && req_ready) begin
                qw.push_back(req_write); qb.push_back(req_bank); qr.push_back(req_row);
                qc.push_back(req_col); qd.push_back(req_wdata);
            end
            if (c != 4'b0111) begin
                if (step < 4) begin
                    case (step)
                        0: begin
                            chk(c == 4'b0010 && sd_addr[10], "R1 precharge-all", c, 4'b0010);
                            chk(n - rel == INIT_WAIT, "R1 wait", n - rel, INIT_WAIT);
                            l_pre = n;
                        end
                        1, 2: begin
                            chk(c == 4'b0001, "R1 refresh", c, 4'b0001);
                            idle_checks(n, "R6");
                            l_ref = n;
                        end
                        default: begin
                            chk(c == 4'b0000, "R1 mode set", c, 4'b0000);
                            chk(sd_addr == 13'h030 && sd_ba == 0, "R2 mode word", sd_addr, 13'h030);
                            idle_checks(n, "R6");
                            l_mrs = n; mrs_cyc = n; prev_ref = n;
                        end
                    endcase
                    step++;
                end else begin
                    case (c)
                        4'b0011: begin
                            idle_checks(n, "R5");
                            chk(qb.size() > 0, "R10 act without request", qb.size(), 1);
                            if (qb.size() > 0) begin
                                chk(sd_ba == qb[0], "R4 act bank", sd_ba, qb[0]);
                                chk(sd_addr == qr[0], "R4 act row", sd_addr, qr[0]);
                            end
                            l_act = n;
                        end
                        4'b0101, 4'b0100: begin
                            int key;
                            chk(n - l_act == T_RCD, "R4 rcd", n - l_act, T_RCD);
                            chk(sd_addr[12:10] == 3'b001, "R4 a10", sd_addr[12:10], 1);
                            if (qb.size() > 0) begin
                                chk(c[0] == !qw[0], "R10 order op", c[0], !qw[0]);
                                chk(sd_ba == qb[0], "R4 col bank", sd_ba, qb[0]);
                                chk(sd_addr[9:0] == qc[0], "R4 col", sd_addr[9:0], qc[0]);
                                key = qb[0] * (1 << 23) + qr[0] * 1024 + qc[0];
                                if (c == 4'b0100) begin
                                    chk(sd_dq_oe, "R8 oe on write", sd_dq_oe, 1);
                                    chk(sd_dq_out == qd[0], "R8 data", sd_dq_out, qd[0]);
                                    mem[key] = sd_dq_out;
                                    l_wr = n;
                                end else begin
                                    int d;
                                    d = mem.exists(key) ? mem[key] : patt(key);
                                    drv_t.push_back(n + CL); drv_d.push_back(d);
                                    rv_t.push_back(n + CL + 1); rv_d.push_back(d);
                                    l_rd = n;
                                end
                                void'(qw.pop_front()); void'(qb.pop_front()); void'(qr.pop_front());
                                void'(qc.pop_front()); void'(qd.pop_front());
                            end else chk(0, "R10 column without request", 0, 1);
                        end
                        4'b0001: begin
                            idle_checks(n, "R6");
                            chk(n - prev_ref <= REF_INTERVAL + SLACK, "R7 interval",
                                n - prev_ref, REF_INTERVAL + SLACK);
                            prev_ref = n; l_ref = n; ref_cnt++;
                        end
                        default: chk(0, "R3 illegal code", c, 4'b0111);
                    endcase
                end
            end
            if (done) chk(n - prev_ref <= REF_INTERVAL + SLACK, "R7 final interval",
                          n - prev_ref, REF_INTERVAL + SLACK);
            sd_dq_in <= 8'h00;
            if (drv_t.size() > 0 && drv_t[0] == n) begin
                sd_dq_in <= drv_d[0][7:0];
                void'(drv_t.pop_front()); void'(drv_d.pop_front());
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic send(input bit wr, input int bank, input int row, input int col, input int data);
        req_valid = 1'b1; req_write = wr; req_bank = 2'(bank); req_row = 13'(row);
        req_col = 10'(col); req_wdata = 8'(data);
        do @(negedge clk); while (!req_ready);
        tick();
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        // R4 R8 corner addresses
        send(1, 0, 0, 0, 8'hA5);
        send(1, 3, 8191, 1023, 8'h3C);
        send(1, 1, 100, 512, 8'hFF);
        send(1, 2, 4095, 1, 8'h00);
        // R9 read-back and never-written location
        send(0, 0, 0, 0, 0);
        send(0, 3, 8191, 1023, 0);
        send(0, 1, 100, 512, 0);
        send(0, 2, 4095, 1, 0);
        send(0, 0, 5, 7, 0);
        // write then read same place back-to-back
        send(1, 2, 77, 300, 8'h81);
        send(0, 2, 77, 300, 0);
        // idle: refresh alone (R6 R7)
        repeat (600) tick();
        // continuous stream (R7 priority, R10 order)
        for (int i = 0; i < 60; i++)
            send(1, i % 4, (i * 37) % 8192, (i * 101) % 1024, (i * 29 + 7) % 256);
        for (int i = 0; i < 60; i++)
            send(0, i % 4, (i * 37) % 8192, (i * 101) % 1024, 0);
        repeat (30) tick();
        done = 1;
        tick();
        chk(qb.size() == 0, "R10 all executed", qb.size(), 0);
        chk(rv_t.size() == 0, "R9 all returned", rv_t.size(), 0);
        chk(ref_cnt >= (ncyc - mrs_cyc) / (REF_INTERVAL + SLACK), "R7 count",
            ref_cnt, (ncyc - mrs_cyc) / (REF_INTERVAL + SLACK));
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule